// File: doc/BRIEF.md
# Knockout Output Port Concentrator

This block holds the per-output logic of a fully connected cell switch. Every input bus offers at most one cell per slot, and each cell carries a destination port number. A filter on each input keeps only the cells addressed to this output. A concentrator then accepts no more than `MAX_ACC` of the surviving cells in one slot and knocks out the rest. The accepted cells go into an output FIFO that can take several writes in one slot. The FIFO releases one cell per slot to the output line.

A one-cycle `slotStrobe` marks each slot boundary. Inputs are sampled only in a cycle where the strobe is high. Two drop counters keep separate tallies. One counts cells lost to the concentrator limit, and the other counts cells lost because the FIFO had no room. The parameter `ROTATE` selects the contention policy. With `ROTATE=0` the lowest input indices always win. With `ROTATE=1` the scan starts from a pointer that moves past the last winner after each slot that knocked cells out.

Top module: `knockout_concentrator`

## Requirements
- R1: An input cell counts as a contender only when its valid bit is 1 and its destination field equals `PORT_ID` (default 5). Any other cell leaves the FIFO, the output and both counters untouched.
- R2: In one slot at most `MAX_ACC` (default 4) contenders are accepted. Each contender beyond that adds one to `knockDrops`.
- R3: With `ROTATE=0` the accepted contenders are the ones with the lowest input indices.
- R4: With `ROTATE=1` the contenders are scanned circularly, starting from a pointer that resets to 0. After a slot with more than `MAX_ACC` contenders, the pointer moves to the input just after the last one accepted. Otherwise it keeps its value.
- R5: The cells accepted in one slot enter the FIFO in ascending input index order.
- R6: In each slot where the FIFO is non-empty, the oldest cell is removed. It appears on `outData`, with `outValid` high for exactly the one cycle after the strobe edge. `outValid` is never high at any other time.
- R7: If the accepted cells exceed the free space, the highest-index accepted cells that do not fit are discarded. Each one adds one to `fullDrops`, and `occupancy` never exceeds `FIFO_DEPTH`.
- R8: Free space is measured before the same slot's departure. A FIFO holding `FIFO_DEPTH-1` cells takes exactly one new cell per slot.
- R9: In cycles where `slotStrobe` is low, the inputs are ignored: occupancy and counters hold, and `outValid` stays low.
- R10: After reset, `outValid`, `occupancy`, `knockDrops` and `fullDrops` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| slotStrobe | input | 1 | High for one cycle per slot; inputs are sampled then |
| inValid | input | NUM_IN | Per-input cell-present flags |
| inDest | input | NUM_IN*DEST_W | Per-input destination fields, input i at bits i*DEST_W |
| inData | input | NUM_IN*DATA_W | Per-input payloads, input i at bits i*DATA_W |
| outValid | output | 1 | Departing cell present |
| outData | output | DATA_W | Departing cell payload |
| occupancy | output | $clog2(FIFO_DEPTH+1) | Cells held in the FIFO |
| knockDrops | output | CNT_W | Running count of cells lost to the acceptance limit |
| fullDrops | output | CNT_W | Running count of cells lost to a full FIFO |

## Verification
The bench drives two instances, one fixed-priority and one rotating, with the same inputs. It first runs a long pseudo-random sweep that mixes invalid cells, cells for other ports and heavy contention. It then runs directed slots with all sixteen inputs contending. A design that scanned in the wrong order, or let the pointer move on quiet slots, would output the wrong payloads. One directed slot puts cells on out-of-order input positions into an empty FIFO, so a design with wrong write order shows a permuted output sequence. Another keeps the FIFO at depth minus one while four cells arrive each slot. A design that counted the departing cell as free space would lose two cells instead of three. Idle cycles carry matching garbage, which catches a design that samples inputs without the strobe.

// File: rtl/kc_pkg.sv
package kc_pkg;
  // Per-slot strobes handed from the control to the datapath.
  typedef struct packed {
    logic       pop;
    logic [7:0] wrNum;
    logic [7:0] knockNum;
    logic [7:0] fullNum;
  } slotStrobes_t;
endpackage

// File: rtl/kc_ctrl.sv
module kc_ctrl #(
  parameter int NUM_IN     = 16,
  parameter int MAX_ACC    = 4,
  parameter int FIFO_DEPTH = 32,
  parameter int DEST_W     = 4,
  parameter int PORT_ID    = 5,
  parameter int ROTATE     = 0,
  parameter int OCC_W      = $clog2(FIFO_DEPTH + 1)
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       slotStrobe,
  input  logic [NUM_IN-1:0]          inValid,
  input  logic [NUM_IN*DEST_W-1:0]   inDest,
  input  logic [OCC_W-1:0]           occ,
  output logic [NUM_IN-1:0]          selMask,
  output kc_pkg::slotStrobes_t       strobes
);
  localparam int PW = (NUM_IN > 1) ? $clog2(NUM_IN) : 1;

  logic [NUM_IN-1:0] matchVec;
  logic [PW-1:0]     ptrQ;
  logic [PW-1:0]     scanStart;
  int                matchCnt;
  int                taken;
  int                lastIdx;
  int                freeN;
  int                wrN;

  // Address filters, one per input
  for (genvar i = 0; i < NUM_IN; i++) begin : g_filter
    assign matchVec[i] = inValid[i] && (inDest[i*DEST_W +: DEST_W] == DEST_W'(PORT_ID));
  end

  assign scanStart = (ROTATE != 0) ? ptrQ : '0;

  // Circular scan from scanStart, first MAX_ACC matches win
  always_comb begin
    selMask = '0;
    taken   = 0;
    lastIdx = int'(scanStart);
    for (int k = 0; k < NUM_IN; k++) begin
      int idx;
      idx = (int'(scanStart) + k) % NUM_IN;
      if (matchVec[idx] && taken < MAX_ACC) begin
        selMask[idx] = 1'b1;
        taken        = taken + 1;
        lastIdx      = idx;
      end
    end
    matchCnt = $countones(matchVec);
    freeN    = FIFO_DEPTH - int'(occ);
    wrN      = (taken < freeN) ? taken : freeN;
  end

  always_comb begin
    strobes = '0;
    if (slotStrobe) begin
      strobes.pop      = (occ != '0);
      strobes.wrNum    = 8'(wrN);
      strobes.knockNum = 8'(matchCnt - taken);
      strobes.fullNum  = 8'(taken - wrN);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptrQ <= '0;
    end else if (slotStrobe && matchCnt > MAX_ACC) begin
      ptrQ <= PW'((lastIdx + 1) % NUM_IN);
    end
  end

  // R2
  knock_full_lanes_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.knockNum != 8'd0) |-> (strobes.wrNum + strobes.fullNum == 8'(MAX_ACC)));
  // R2
  accept_cap_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.wrNum <= 8'(MAX_ACC));
  // R4
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.knockNum == 8'd0) |=> (ptrQ == $past(ptrQ)));
endmodule

// File: rtl/kc_datapath.sv
module kc_datapath #(
  parameter int NUM_IN     = 16,
  parameter int MAX_ACC    = 4,
  parameter int FIFO_DEPTH = 32,
  parameter int DATA_W     = 16,
  parameter int CNT_W      = 16,
  parameter int OCC_W      = $clog2(FIFO_DEPTH + 1)
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [NUM_IN*DATA_W-1:0]   inData,
  input  logic [NUM_IN-1:0]          selMask,
  input  kc_pkg::slotStrobes_t       strobes,
  output logic [OCC_W-1:0]           occ,
  output logic                       outValid,
  output logic [DATA_W-1:0]          outData,
  output logic [CNT_W-1:0]           knockTotal,
  output logic [CNT_W-1:0]           fullTotal
);
  localparam int AW = $clog2(FIFO_DEPTH);

  logic [DATA_W-1:0] mem [FIFO_DEPTH];
  logic [AW-1:0]     wrPtr;
  logic [AW-1:0]     rdPtr;
  logic [DATA_W-1:0] laneData [MAX_ACC];
  int                rank;

  // Compact the selected payloads into lanes, ascending input order
  always_comb begin
    for (int j = 0; j < MAX_ACC; j++) laneData[j] = '0;
    rank = 0;
    for (int i = 0; i < NUM_IN; i++) begin
      for (int j = 0; j < MAX_ACC; j++) begin
        if (selMask[i] && rank == j) laneData[j] = inData[i*DATA_W +: DATA_W];
      end
      if (selMask[i]) rank = rank + 1;
    end
  end

  always_ff @(posedge clk) begin
    for (int j = 0; j < MAX_ACC; j++) begin
      if (8'(j) < strobes.wrNum) mem[wrPtr + AW'(j)] <= laneData[j];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr      <= '0;
      rdPtr      <= '0;
      occ        <= '0;
      outValid   <= 1'b0;
      outData    <= '0;
      knockTotal <= '0;
      fullTotal  <= '0;
    end else begin
      wrPtr      <= wrPtr + AW'(strobes.wrNum);
      rdPtr      <= rdPtr + AW'(strobes.pop);
      occ        <= occ + OCC_W'(strobes.wrNum) - OCC_W'(strobes.pop);
      outValid   <= strobes.pop;
      if (strobes.pop) outData <= mem[rdPtr];
      knockTotal <= knockTotal + CNT_W'(strobes.knockNum);
      fullTotal  <= fullTotal + CNT_W'(strobes.fullNum);
    end
  end

  // R7
  occ_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    occ <= OCC_W'(FIFO_DEPTH));
  // R6
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.pop |-> (occ != '0));
  // R7
  full_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.fullNum != 8'd0) |=> (occ == OCC_W'(FIFO_DEPTH) - OCC_W'($past(strobes.pop))));
endmodule

// File: rtl/knockout_concentrator.sv
module knockout_concentrator #(
  parameter int NUM_IN     = 16,
  parameter int MAX_ACC    = 4,
  parameter int FIFO_DEPTH = 32,
  parameter int DATA_W     = 16,
  parameter int DEST_W     = 4,
  parameter int PORT_ID    = 5,
  parameter int ROTATE     = 0,
  parameter int CNT_W      = 16,
  localparam int OCC_W     = $clog2(FIFO_DEPTH + 1)
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       slotStrobe,
  input  logic [NUM_IN-1:0]          inValid,
  input  logic [NUM_IN*DEST_W-1:0]   inDest,
  input  logic [NUM_IN*DATA_W-1:0]   inData,
  output logic                       outValid,
  output logic [DATA_W-1:0]          outData,
  output logic [OCC_W-1:0]           occupancy,
  output logic [CNT_W-1:0]           knockDrops,
  output logic [CNT_W-1:0]           fullDrops
);
  kc_pkg::slotStrobes_t strobes;
  logic [NUM_IN-1:0]    selMask;

  kc_ctrl #(
    .NUM_IN(NUM_IN), .MAX_ACC(MAX_ACC), .FIFO_DEPTH(FIFO_DEPTH),
    .DEST_W(DEST_W), .PORT_ID(PORT_ID), .ROTATE(ROTATE), .OCC_W(OCC_W)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .slotStrobe(slotStrobe),
    .inValid(inValid), .inDest(inDest), .occ(occupancy),
    .selMask(selMask), .strobes(strobes)
  );

  kc_datapath #(
    .NUM_IN(NUM_IN), .MAX_ACC(MAX_ACC), .FIFO_DEPTH(FIFO_DEPTH),
    .DATA_W(DATA_W), .CNT_W(CNT_W), .OCC_W(OCC_W)
  ) i_datapath (
    .clk(clk), .rstN(rstN), .inData(inData), .selMask(selMask),
    .strobes(strobes), .occ(occupancy), .outValid(outValid),
    .outData(outData), .knockTotal(knockDrops), .fullTotal(fullDrops)
  );

  // R6
  pulse_after_slot_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(slotStrobe));
endmodule

// File: tb/test_knockout_concentrator.sv
module test_knockout_concentrator;
  localparam int CLK_PERIOD = 10;
  localparam int N = 16;
  localparam int L = 4;
  localparam int DEPTH = 32;
  localparam int PID = 5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic slotStrobe = 1'b0;
  logic [N-1:0] inValid = '0;
  logic [N*4-1:0] inDest = '0;
  logic [N*16-1:0] inData = '0;

  logic outValidF, outValidR;
  logic [15:0] outDataF, outDataR;
  logic [5:0] occF, occR;
  logic [15:0] knockF, knockR, fullF, fullR;

  int checks = 0;
  int failures = 0;
  logic [15:0] qA[$];
  logic [15:0] qB[$];
  int ptrS[2];
  int knockS[2];
  int fullS[2];
  logic expV[2];
  logic [15:0] expD[2];
  logic [31:0] lfsr = 32'h1ACE_B00C;

  always #(CLK_PERIOD/2) clk = ~clk;

  knockout_concentrator #(.ROTATE(0)) i_knockout_concentrator (
    .clk(clk), .rstN(rstN), .slotStrobe(slotStrobe), .inValid(inValid),
    .inDest(inDest), .inData(inData), .outValid(outValidF), .outData(outDataF),
    .occupancy(occF), .knockDrops(knockF), .fullDrops(fullF));

  knockout_concentrator #(.ROTATE(1)) i_knockout_concentrator_rot (
    .clk(clk), .rstN(rstN), .slotStrobe(slotStrobe), .inValid(inValid),
    .inDest(inDest), .inData(inData), .outValid(outValidR), .outData(outDataR),
    .occupancy(occR), .knockDrops(knockR), .fullDrops(fullR));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic modelSlot(input int m, input logic [15:0] vm, input logic [15:0] hm, input int sn);
    int sz, freeN, taken, matchCnt, last, idx, wr, cnt;
    logic [15:0] sel;
    sz = (m == 0) ? qA.size() : qB.size();
    freeN = DEPTH - sz;
    expV[m] = 1'b0;
    expD[m] = '0;
    if (sz > 0) begin
      expV[m] = 1'b1;
      if (m == 0) expD[m] = qA.pop_front();
      else expD[m] = qB.pop_front();
    end
    sel = '0; taken = 0; matchCnt = 0; last = ptrS[m];
    for (int k = 0; k < N; k++) begin
      idx = (((m == 0) ? 0 : ptrS[m]) + k) % N;
      if (vm[idx] && hm[idx]) begin
        matchCnt++;
        if (taken < L) begin sel[idx] = 1'b1; taken++; last = idx; end
      end
    end
    knockS[m] += matchCnt - taken;
    if (m == 1 && matchCnt > L) ptrS[m] = (last + 1) % N;
    wr = (taken < freeN) ? taken : freeN;
    fullS[m] += taken - wr;
    cnt = 0;
    for (int i = 0; i < N; i++) begin
      if (sel[i] && cnt < wr) begin
        if (m == 0) qA.push_back(16'(sn*16 + i));
        else qB.push_back(16'(sn*16 + i));
        cnt++;
      end
    end
  endtask

  task automatic runSlot(input logic [15:0] vm, input logic [15:0] hm, input int sn);
    logic [5:0] holdOcc;
    logic [15:0] holdKnock;
    for (int i = 0; i < N; i++) begin
      inValid[i] = vm[i];
      inDest[i*4 +: 4] = hm[i] ? 4'(PID) : ((i % 2 == 1) ? 4'd3 : 4'd12);
      inData[i*16 +: 16] = 16'(sn*16 + i);
    end
    slotStrobe = 1'b1;
    modelSlot(0, vm, hm, sn);
    modelSlot(1, vm, hm, sn);
    @(negedge clk);
    // idle cycle carries matching garbage that must be ignored
    slotStrobe = 1'b0;
    inValid = '1;
    for (int i = 0; i < N; i++) begin
      inDest[i*4 +: 4] = 4'(PID);
      inData[i*16 +: 16] = 16'hDEAD;
    end
    check("R6", 32'(outValidF), 32'(expV[0]));
    check("R6", 32'(outValidR), 32'(expV[1]));
    if (expV[0]) check("R3", 32'(outDataF), 32'(expD[0]));
    if (expV[1]) check("R4", 32'(outDataR), 32'(expD[1]));
    check("R7", 32'(occF), 32'(qA.size()));
    check("R7", 32'(occR), 32'(qB.size()));
    check("R2", 32'(knockF), 32'(16'(knockS[0])));
    check("R2", 32'(knockR), 32'(16'(knockS[1])));
    check("R7", 32'(fullF), 32'(16'(fullS[0])));
    check("R7", 32'(fullR), 32'(16'(fullS[1])));
    holdOcc = occF;
    holdKnock = knockF;
    @(negedge clk);
    check("R9", 32'(outValidF), 32'd0);
    check("R9", 32'(occF), 32'(holdOcc));
    check("R9", 32'(knockF), 32'(holdKnock));
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : stimulus
    logic [15:0] k0, f0;
    int sn;
    for (int m = 0; m < 2; m++) begin ptrS[m] = 0; knockS[m] = 0; fullS[m] = 0; end
    repeat (3) @(negedge clk);
    check("R10", 32'(outValidF), 32'd0);
    check("R10", 32'(occF), 32'd0);
    check("R10", 32'(knockF), 32'd0);
    check("R10", 32'(fullF), 32'd0);
    check("R10", 32'(occR), 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    sn = 1;

    // R1: cells for other ports, and invalid cells for this port
    k0 = knockF;
    runSlot(16'hFFFF, 16'h0000, sn); sn++;
    runSlot(16'h0000, 16'hFFFF, sn); sn++;
    check("R1", 32'(knockF), 32'(k0));
    check("R1", 32'(occF), 32'd0);
    check("R1", 32'(fullF), 32'd0);

    // R2: all sixteen contend
    k0 = knockF;
    runSlot(16'hFFFF, 16'hFFFF, sn); sn++;
    check("R2", 32'(knockF - k0), 32'd12);
    check("R2", 32'(occF), 32'd4);

    // pseudo-random sweep
    for (int s = 0; s < 300; s++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      runSlot(lfsr[15:0], lfsr[31:16], sn); sn++;
    end

    // drain
    for (int s = 0; s < 40; s++) begin runSlot(16'h0000, 16'h0000, sn); sn++; end
    check("R6", 32'(occF), 32'd0);

    // R5: scattered inputs into an empty FIFO leave in ascending order
    begin
      int s0;
      s0 = sn;
      runSlot(16'h4204, 16'h4204, sn); sn++;
      runSlot(16'h0000, 16'h0000, sn); sn++;
      check("R5", 32'(outDataF), 32'(16'(s0*16 + 2)));
      runSlot(16'h0000, 16'h0000, sn); sn++;
      check("R5", 32'(outDataF), 32'(16'(s0*16 + 9)));
      runSlot(16'h0000, 16'h0000, sn); sn++;
      check("R5", 32'(outDataF), 32'(16'(s0*16 + 14)));
    end

    // R8: occupancy held at depth-1 takes one cell per slot
    for (int s = 0; s < 11; s++) begin runSlot(16'h000F, 16'h000F, sn); sn++; end
    f0 = fullF;
    runSlot(16'h000F, 16'h000F, sn); sn++;
    check("R8", 32'(fullF - f0), 32'd3);
    check("R8", 32'(occF), 32'(DEPTH - 1));

    // R4: repeated full contention on the rotating instance
    for (int s = 0; s < 40; s++) begin runSlot(16'h0000, 16'h0000, sn); sn++; end
    for (int s = 0; s < 6; s++) begin runSlot(16'hFFFF, 16'hFFFF, sn); sn++; end
    for (int s = 0; s < 30; s++) begin runSlot(16'h0000, 16'h0000, sn); sn++; end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule